// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Processor Core

This block is a small 32-bit processor core that fetches, decodes and completes one instruction on every clock edge. The instruction at the program counter is read from an instruction store, its fields drive a register file, an arithmetic unit and a data store, and the next program counter is formed in the same cycle. Five instruction classes are supported:

- register-to-register arithmetic and logic
- load word
- store word
- branch when two registers are equal
- unconditional jump

Both memories are loaded through dedicated write ports that are honoured only while reset is held. After reset is released the core runs from address 0. A registered debug port lets a test environment read any architectural register without disturbing execution.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high, the PC is 0, every register reads as 0, and the load ports (`imem_ld_we`, `dmem_ld_we`) write the word at their word index into the instruction or data store.
- R2: With `rst` low, each rising edge completes exactly one instruction. An instruction that is not a taken branch or a jump sets the PC to PC+4. The PC is always word aligned.
- R3: Opcode 0x00 is register arithmetic, selected by bits 5:0: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, 0x2A signed set-less-than (result 1 or 0). Sources are the registers in bits 25:21 and 20:16. The result goes to the register in bits 15:11. Any other value in bits 5:0 writes nothing.
- R4: Opcode 0x23 loads a word. The address is register[25:21] plus the sign-extended bits 15:0. The data store is indexed by the address bits above bit 1, wrapping at the store depth. The word is written to the register in bits 20:16.
- R5: Opcode 0x2B stores register[20:16] at the address formed as in R4. It writes no register.
- R6: Opcode 0x04 compares register[25:21] and register[20:16] by subtraction. If they are equal, the next PC is PC+4 plus the sign-extended bits 15:0 shifted left by two. Otherwise it is PC+4.
- R7: Opcode 0x02 sets the next PC to bits 31:28 of PC+4, followed by instruction bits 25:0, followed by two zero bits.
- R8: Register 0 always reads as 0. Writes to it are discarded.
- R9: Any other opcode writes neither a register nor the data store, and advances the PC by 4.
- R10: `dbg_rdata` shows, one edge later, the register selected by `dbg_raddr` as it stood before that edge's write.
- R11: The load ports have no effect while `rst` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset; enables memory loading |
| imem_ld_we | input | 1 | Instruction store load strobe |
| imem_ld_addr | input | IMEM_AW | Instruction store word index |
| imem_ld_data | input | 32 | Instruction word to load |
| dmem_ld_we | input | 1 | Data store load strobe |
| dmem_ld_addr | input | DMEM_AW | Data store word index |
| dmem_ld_data | input | 32 | Data word to load |
| dbg_raddr | input | 5 | Register to observe |
| dbg_rdata | output | 32 | Registered value of the observed register |
| pc_out | output | 32 | Current program counter |

## Verification
A register write-back and a register read for a later instruction can fall in the same edge. So can a store and the fetch or load that follows it, and a branch decision can use a register written on the previous edge. Random programs over a few registers create these dependencies constantly. A bench reference model steps alongside the core. The bench compares the PC on every cycle, and it compares one register per cycle through the debug port against the model's state before the last step. That second comparison catches a write that lands a cycle early or late.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int XLEN = 32;
  localparam int RIDX = 5;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_STORE = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_JUMP  = 6'h02;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  // operation class issued by the main decoder
  typedef enum logic [1:0] {
    CLS_ADDR = 2'b00,
    CLS_CMP  = 2'b01,
    CLS_FUNC = 2'b10
  } alu_cls_e;

  // function select seen by the arithmetic unit
  typedef enum logic [2:0] {
    AF_AND = 3'b000,
    AF_OR  = 3'b001,
    AF_ADD = 3'b010,
    AF_SUB = 3'b110,
    AF_SLT = 3'b111
  } alu_fn_e;

  typedef struct packed {
    logic     dst_is_rd;
    logic     b_is_imm;
    logic     wb_from_mem;
    logic     rf_we;
    logic     dm_we;
    logic     is_branch;
    logic     is_jump;
    alu_cls_e cls;
  } ctrl_t;
endpackage

// File: rtl/sc_decode.sv
module sc_decode
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl,
  output alu_fn_e    fn
);
  logic fn_ok;

  always_comb begin
    ctrl = '0;
    ctrl.cls = CLS_ADDR;
    unique case (opcode)
      OP_RTYPE: begin
        ctrl.dst_is_rd = 1'b1;
        ctrl.rf_we     = fn_ok;
        ctrl.cls       = CLS_FUNC;
      end
      OP_LOAD: begin
        ctrl.b_is_imm    = 1'b1;
        ctrl.wb_from_mem = 1'b1;
        ctrl.rf_we       = 1'b1;
      end
      OP_STORE: begin
        ctrl.b_is_imm = 1'b1;
        ctrl.dm_we    = 1'b1;
      end
      OP_BEQ: begin
        ctrl.is_branch = 1'b1;
        ctrl.cls       = CLS_CMP;
      end
      OP_JUMP: ctrl.is_jump = 1'b1;
      default: ;
    endcase
  end

  always_comb begin
    fn    = AF_ADD;
    fn_ok = 1'b1;
    unique case (ctrl.cls)
      CLS_ADDR: fn = AF_ADD;
      CLS_CMP:  fn = AF_SUB;
      default: begin
        unique case (funct)
          FN_ADD:  fn = AF_ADD;
          FN_SUB:  fn = AF_SUB;
          FN_AND:  fn = AF_AND;
          FN_OR:   fn = AF_OR;
          FN_SLT:  fn = AF_SLT;
          default: begin
            fn    = AF_ADD;
            fn_ok = 1'b0;
          end
        endcase
      end
    endcase
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_fn_e      fn,
  output logic [W-1:0] y,
  output logic         zero
);
  logic [W-1:0] diff;

  assign diff = a - b;

  always_comb begin
    unique case (fn)
      AF_AND:  y = a & b;
      AF_OR:   y = a | b;
      AF_SUB:  y = diff;
      AF_SLT:  y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = a + b;
    endcase
  end

  assign zero = (y == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int W  = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] dbg_a,
  output logic [W-1:0]  dbg_d
);
  localparam int N = 1 << AW;
  logic [W-1:0] regs [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) regs[i] <= '0;
    end else if (we && wa != '0) begin
      regs[wa] <= wd;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) dbg_d <= '0;
    else     dbg_d <= (dbg_a == '0) ? '0 : regs[dbg_a];
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];
endmodule

// File: rtl/sc_ram.sv
module sc_ram #(
  parameter int W  = 32,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra,
  output logic [W-1:0]  rd
);
  localparam int DEPTH = 1 << AW;
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  assign rd = mem[ra];
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int IMEM_AW = 8,
  parameter int DMEM_AW = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               imem_ld_we,
  input  logic [IMEM_AW-1:0] imem_ld_addr,
  input  logic [XLEN-1:0]    imem_ld_data,
  input  logic               dmem_ld_we,
  input  logic [DMEM_AW-1:0] dmem_ld_addr,
  input  logic [XLEN-1:0]    dmem_ld_data,
  input  logic [RIDX-1:0]    dbg_raddr,
  output logic [XLEN-1:0]    dbg_rdata,
  output logic [XLEN-1:0]    pc_out
);
  logic [XLEN-1:0] pc, pc4, pc_nxt, instr, imm, br_tgt, j_tgt;
  logic [XLEN-1:0] rd1, rd2, alu_b, alu_y, dm_rd, wb_data;
  logic [RIDX-1:0] wr_idx;
  logic            zero, rf_we;
  ctrl_t           ctrl;
  alu_fn_e         fn;

  logic               dm_we;
  logic [DMEM_AW-1:0] dm_wa;
  logic [XLEN-1:0]    dm_wd;

  sc_ram #(.W(XLEN), .AW(IMEM_AW)) u_imem (
    .clk(clk), .we(rst & imem_ld_we), .wa(imem_ld_addr), .wd(imem_ld_data),
    .ra(pc[IMEM_AW+1:2]), .rd(instr)
  );

  sc_decode u_dec (
    .opcode(instr[31:26]), .funct(instr[5:0]), .ctrl(ctrl), .fn(fn)
  );

  assign imm    = {{16{instr[15]}}, instr[15:0]};
  assign wr_idx = ctrl.dst_is_rd ? instr[15:11] : instr[20:16];
  assign rf_we  = ctrl.rf_we & ~rst;

  sc_regfile #(.W(XLEN), .AW(RIDX)) u_rf (
    .clk(clk), .rst(rst),
    .ra1(instr[25:21]), .ra2(instr[20:16]), .rd1(rd1), .rd2(rd2),
    .we(rf_we), .wa(wr_idx), .wd(wb_data),
    .dbg_a(dbg_raddr), .dbg_d(dbg_rdata)
  );

  assign alu_b = ctrl.b_is_imm ? imm : rd2;

  sc_alu #(.W(XLEN)) u_alu (
    .a(rd1), .b(alu_b), .fn(fn), .y(alu_y), .zero(zero)
  );

  // one write port: loader during reset, store instructions afterwards
  assign dm_we = rst ? dmem_ld_we   : ctrl.dm_we;
  assign dm_wa = rst ? dmem_ld_addr : alu_y[DMEM_AW+1:2];
  assign dm_wd = rst ? dmem_ld_data : rd2;

  sc_ram #(.W(XLEN), .AW(DMEM_AW)) u_dmem (
    .clk(clk), .we(dm_we), .wa(dm_wa), .wd(dm_wd),
    .ra(alu_y[DMEM_AW+1:2]), .rd(dm_rd)
  );

  assign wb_data = ctrl.wb_from_mem ? dm_rd : alu_y;

  assign pc4    = pc + 32'd4;
  assign br_tgt = pc4 + {imm[XLEN-3:0], 2'b00};
  assign j_tgt  = {pc4[31:28], instr[25:0], 2'b00};

  always_comb begin
    if (ctrl.is_jump)               pc_nxt = j_tgt;
    else if (ctrl.is_branch && zero) pc_nxt = br_tgt;
    else                            pc_nxt = pc4;
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pc_nxt;
  end

  assign pc_out = pc;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] pc_out,
  input logic [31:0] instr,
  input logic [31:0] rd1,
  input logic [31:0] rd2,
  input logic        rf_we,
  input logic        dm_we,
  input logic [4:0]  dbg_raddr,
  input logic [31:0] dbg_rdata
);
  logic [5:0] op;
  logic       op_known;
  assign op       = instr[31:26];
  assign op_known = (op == 6'h00) || (op == 6'h23) || (op == 6'h2B) ||
                    (op == 6'h04) || (op == 6'h02);

  // R1
  reset_pc_chk: assert property (@(posedge clk) rst |=> pc_out == 32'd0);

  // R2
  pc_align_chk: assert property (@(posedge clk) disable iff (rst)
    pc_out[1:0] == 2'b00);

  // R5
  store_no_wb_chk: assert property (@(posedge clk) disable iff (rst)
    (op == 6'h2B) |-> !rf_we);

  // R6
  beq_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (op == 6'h04 && rd1 != rd2) |=> pc_out == $past(pc_out) + 32'd4);

  // R7
  jump_tgt_chk: assert property (@(posedge clk) disable iff (rst)
    (op == 6'h02) |=> pc_out[27:0] == {$past(instr[25:0]), 2'b00});

  // R9
  bad_op_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !op_known |-> (!rf_we && !dm_we));

  // R9
  bad_op_pc_chk: assert property (@(posedge clk) disable iff (rst)
    !op_known |=> pc_out == $past(pc_out) + 32'd4);

  // R8
  zero_reg_chk: assert property (@(posedge clk) disable iff (rst)
    (dbg_raddr == 5'd0) |=> dbg_rdata == 32'd0);
endmodule

bind sc_core sc_core_chk u_chk (
  .clk(clk), .rst(rst), .pc_out(pc_out), .instr(instr),
  .rd1(rd1), .rd2(rd2), .rf_we(rf_we), .dm_we(dm_we),
  .dbg_raddr(dbg_raddr), .dbg_rdata(dbg_rdata)
);

// File: tb/sc_core_test.sv
`timescale 1ns/1ps
module sc_core_test;
  localparam int IAW = 8;
  localparam int DAW = 8;
  localparam int ID  = 1 << IAW;
  localparam int DD  = 1 << DAW;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           imem_ld_we = 1'b0;
  logic [IAW-1:0] imem_ld_addr = '0;
  logic [31:0]    imem_ld_data = '0;
  logic           dmem_ld_we = 1'b0;
  logic [DAW-1:0] dmem_ld_addr = '0;
  logic [31:0]    dmem_ld_data = '0;
  logic [4:0]     dbg_raddr = '0;
  logic [31:0]    dbg_rdata;
  logic [31:0]    pc_out;

  always #5 clk = ~clk;

  sc_core #(.IMEM_AW(IAW), .DMEM_AW(DAW)) uut (
    .clk(clk), .rst(rst),
    .imem_ld_we(imem_ld_we), .imem_ld_addr(imem_ld_addr), .imem_ld_data(imem_ld_data),
    .dmem_ld_we(dmem_ld_we), .dmem_ld_addr(dmem_ld_addr), .dmem_ld_data(dmem_ld_data),
    .dbg_raddr(dbg_raddr), .dbg_rdata(dbg_rdata), .pc_out(pc_out)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [31:0] mim [ID];
  logic [31:0] mdm [DD];
  logic [31:0] mrg [32];
  logic [31:0] snap [32];
  logic [31:0] mpc;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(input logic [5:0] fn, input int rs, input int rt, input int rd);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  function automatic logic [31:0] enc_j(input int idx);
    return {6'h02, 26'(idx)};
  endfunction

  // reference step built from the requirements
  task automatic model_step();
    logic [31:0] i, a, b, im, pc4, nxt, res, ad;
    logic ok;
    i   = mim[mpc[IAW+1:2]];
    a   = mrg[i[25:21]];
    b   = mrg[i[20:16]];
    im  = {{16{i[15]}}, i[15:0]};
    pc4 = mpc + 32'd4;
    nxt = pc4;
    ad  = a + im;
    case (i[31:26])
      6'h00: begin
        ok = 1'b1;
        case (i[5:0])
          6'h20: res = a + b;
          6'h22: res = a - b;
          6'h24: res = a & b;
          6'h25: res = a | b;
          6'h2A: res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
          default: begin res = '0; ok = 1'b0; end
        endcase
        if (ok && i[15:11] != 5'd0) mrg[i[15:11]] = res;
      end
      6'h23: if (i[20:16] != 5'd0) mrg[i[20:16]] = mdm[ad[DAW+1:2]];
      6'h2B: mdm[ad[DAW+1:2]] = b;
      6'h04: if (a == b) nxt = pc4 + {im[29:0], 2'b00};
      6'h02: nxt = {pc4[31:28], i[25:0], 2'b00};
      default: ;
    endcase
    mpc = nxt;
  endtask

  // hold reset, load both stores, check reset state (R1), release at a falling edge
  task automatic load_and_start();
    rst = 1'b1;
    for (int k = 0; k < ID; k++) begin
      @(negedge clk);
      imem_ld_we = 1'b1; imem_ld_addr = IAW'(k); imem_ld_data = mim[k];
      dmem_ld_we = 1'b1; dmem_ld_addr = DAW'(k); dmem_ld_data = mdm[k];
    end
    @(negedge clk);
    imem_ld_we = 1'b0; dmem_ld_we = 1'b0;
    dbg_raddr = 5'd3;
    @(negedge clk);
    check("R1 pc in reset", pc_out, 32'd0);
    check("R1 register cleared", dbg_rdata, 32'd0);
    for (int r = 0; r < 32; r++) mrg[r] = '0;
    mpc = '0;
    rst = 1'b0;
  endtask

  // lockstep run: PC every cycle, one register per cycle via debug port (R2, R10)
  task automatic run(input int cycles, input string tag);
    int prev;
    prev = 0;
    for (int k = 0; k <= cycles; k++) begin
      if (k > 0) begin
        @(negedge clk);
        check({"R2 pc ", tag}, pc_out, mpc);
        check({"R10 dbg ", tag}, dbg_rdata, snap[prev]);
      end
      for (int r = 0; r < 32; r++) snap[r] = mrg[r];
      prev = k % 32;
      dbg_raddr = 5'(prev);
      model_step();
    end
  endtask

  task automatic read_reg(input int r, output logic [31:0] v);
    @(negedge clk);
    dbg_raddr = 5'(r);
    @(negedge clk);
    v = dbg_rdata;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5EED_0042));

    // ---------------- directed program ----------------
    for (int k = 0; k < ID; k++) mim[k] = '0;
    for (int k = 0; k < DD; k++) mdm[k] = 32'(k) * 32'h0101_0101;
    mdm[0] = 32'd5;
    mdm[1] = 32'hFFFF_FFFD;
    mim[0]  = enc_i(6'h23, 0, 1, 0);        // r1 = 5
    mim[1]  = enc_i(6'h23, 0, 2, 4);        // r2 = -3
    mim[2]  = enc_r(6'h20, 1, 2, 3);        // R3 add
    mim[3]  = enc_r(6'h22, 1, 2, 4);        // R3 sub
    mim[4]  = enc_r(6'h24, 1, 2, 5);        // R3 and
    mim[5]  = enc_r(6'h25, 1, 2, 6);        // R3 or
    mim[6]  = enc_r(6'h2A, 2, 1, 7);        // R3 slt signed
    mim[7]  = enc_r(6'h20, 1, 1, 0);        // R8 write to r0
    mim[8]  = enc_i(6'h2B, 0, 3, 8);        // R5 store r3
    mim[9]  = enc_i(6'h23, 0, 8, 8);        // R4 reload into r8
    mim[10] = enc_i(6'h04, 1, 2, 5);        // R6 not taken
    mim[11] = enc_i(6'h04, 3, 8, 1);        // R6 taken -> 52
    mim[12] = enc_r(6'h20, 1, 1, 10);       // skipped
    mim[13] = 32'hFC00_0000 | enc_r(6'h20, 1, 1, 12); // R9 unknown opcode 0x3F
    mim[14] = enc_j(16);                    // R7 -> 64
    mim[15] = enc_r(6'h20, 1, 1, 11);       // skipped
    mim[16] = enc_i(6'h04, 0, 0, -1);       // self loop
    mim[17] = enc_r(6'h21, 1, 1, 13);       // R3 bad funct (never reached here)
    load_and_start();
    run(30, "directed");

    read_reg(3, v);  check("R3 add result", v, 32'd2);
    read_reg(4, v);  check("R3 sub result", v, 32'd8);
    read_reg(5, v);  check("R3 and result", v, 32'd5);
    read_reg(6, v);  check("R3 or result", v, 32'hFFFF_FFFD);
    read_reg(7, v);  check("R3 slt signed", v, 32'd1);
    read_reg(0, v);  check("R8 r0 stays zero", v, 32'd0);
    read_reg(8, v);  check("R4/R5 store then load", v, 32'd2);
    read_reg(10, v); check("R6 taken branch skipped", v, 32'd0);
    read_reg(12, v); check("R9 unknown opcode no write", v, 32'd0);
    read_reg(11, v); check("R7 jump skipped", v, 32'd0);
    check("R7/R6 loop pc", pc_out, 32'd64);

    // R11: load port strobed while running must not alter the loop
    @(negedge clk);
    imem_ld_we = 1'b1; imem_ld_addr = IAW'(16); imem_ld_data = enc_j(0);
    dmem_ld_we = 1'b1; dmem_ld_addr = DAW'(2); dmem_ld_data = 32'hDEAD_BEEF;
    @(negedge clk);
    imem_ld_we = 1'b0; dmem_ld_we = 1'b0;
    repeat (3) @(negedge clk);
    check("R11 imem load ignored", pc_out, 32'd64);

    // bad funct path, directed: R3
    for (int k = 0; k < ID; k++) mim[k] = '0;
    mim[0] = enc_i(6'h23, 0, 1, 0);
    mim[1] = enc_r(6'h21, 1, 1, 9);
    mim[2] = enc_i(6'h04, 0, 0, -1);
    load_and_start();
    run(6, "badfunct");
    read_reg(9, v); check("R3 unknown funct no write", v, 32'd0);

    // ---------------- random programs ----------------
    for (int p = 0; p < 4; p++) begin
      for (int k = 0; k < DD; k++) mdm[k] = $urandom();
      for (int k = 0; k < ID; k++) begin
        int c, rs, rt, rd, im;
        c  = $urandom_range(0, 9);
        rs = $urandom_range(0, 7);
        rt = $urandom_range(0, 7);
        rd = $urandom_range(0, 7);
        im = $urandom_range(0, 63) - 32;
        case (c)
          0, 1, 2: begin
            logic [5:0] f;
            case ($urandom_range(0, 5))
              0: f = 6'h20; 1: f = 6'h22; 2: f = 6'h24;
              3: f = 6'h25; 4: f = 6'h2A; default: f = 6'h27;
            endcase
            mim[k] = enc_r(f, rs, rt, rd);
          end
          3, 4: mim[k] = enc_i(6'h23, rs, rt, im * 4);
          5, 6: mim[k] = enc_i(6'h2B, rs, rt, im * 4);
          7:    mim[k] = enc_i(6'h04, rs, rt, im / 4);
          8:    mim[k] = enc_j($urandom_range(0, ID - 1));
          default: mim[k] = enc_i(6'h0D, rs, rt, im);
        endcase
      end
      load_and_start();
      run(400, "random");
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule